// File: doc/BRIEF.md
# Block Storage Command Front End

This block sits between user logic and the command engine of a networked storage host. The user issues fixed-size block writes and reads over one shared request bus. A single `stall` output answers both whether a command is accepted and whether a write-data beat is taken. Every command moves `BEATS` data words, which at the default settings is 512 beats of 64 bits, or 4 KiB. The address counts 512-byte sectors, so a legal command starts on a 4 KiB boundary.

When a command is accepted, the block produces one descriptor (an opcode and an address) on a valid/ready output. A write also produces its data beats on a second valid/ready output. After acceptance the block holds `stall` high for a fixed pre-processing window. After the final write beat it holds `stall` high for a fixed post-processing window.

The block tracks two limits:
- The number of commands that are outstanding, bounded by a queue limit. Each `cmd_done` pulse retires one command.
- A pool of read credits, modelling free space in the read reorder buffer. Each accepted read takes one credit and each `credit_ret` pulse gives one back.

Illegal requests are dropped and recorded in sticky error bits.

Top module: `blkcmd_front`

## Requirements
- R1: Each accepted command raises `cmd_valid` in the next cycle and holds it until `cmd_ready`. The descriptor carries the request address and `cmd_is_write` (1 = write, 0 = read).
- R2: A write forwards exactly `BEATS` data beats on `wd_*`, in the order they were offered. The first of these is the beat presented together with the request. A read forwards no data beats.
- R3: The user may leave gaps in `req_wr` during a write. While a taken beat waits on `wd_ready` low, `stall` is high and `wd_data` stays stable.
- R4: After a write or a read is accepted, `stall` is high for exactly `PRE_STALL` cycles (9 by default) before anything further is taken.
- R5: After the last beat of a write is taken, `stall` is high for `POST_STALL` cycles (1 by default). This gives at least 10 stall cycles per write.
- R6: A request whose address has a nonzero value in bits [2:0] is not accepted and sets `proto_err[1]`.
- R7: A cycle in which `req_wr` and `req_rd` are both high is ignored and sets `proto_err[0]`. So is a `req_rd` during a write's data phase. Both error bits stay set until reset.
- R8: No command is accepted while `MAX_OUTST` commands are outstanding. A `cmd_done` pulse retires one command and lets acceptance resume.
- R9: Each accepted read takes one of `RD_CREDITS` credits. While no credit is left, no command of either type is accepted. A `credit_ret` pulse returns one credit.
- R10: `busy` rises in the cycle after an acceptance. It stays high until the outstanding count returns to zero.
- R11: After reset, `stall`, `busy`, `cmd_valid`, `wd_valid` and `proto_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_wr | input | 1 | Write request, or write beat strobe |
| req_rd | input | 1 | Read request |
| req_addr | input | ADDR_W | Sector address, 512-byte units |
| wr_data | input | DATA_W | Write data beat |
| stall | output | 1 | Request or beat not taken this cycle |
| busy | output | 1 | Commands outstanding |
| proto_err | output | 2 | Sticky errors: [0] strobe clash, [1] misaligned |
| cmd_valid | output | 1 | Descriptor valid |
| cmd_ready | input | 1 | Descriptor taken |
| cmd_is_write | output | 1 | Descriptor opcode |
| cmd_addr | output | ADDR_W | Descriptor address |
| wd_valid | output | 1 | Write data valid |
| wd_ready | input | 1 | Write data taken |
| wd_data | output | DATA_W | Write data |
| cmd_done | input | 1 | Completion pulse, retires one command |
| credit_ret | input | 1 | Read credit return pulse |

## Verification
The assertions assume a well-behaved downstream side:
- It never pulses `cmd_done` with nothing outstanding.
- It never returns more credits than it took.
- It leaves `wd_ready` free to change, but never relies on `wd_data` changing while a beat waits.

The bench keeps to these assumptions. It issues exactly one `cmd_done` per accepted command and one `credit_ret` per accepted read. It changes inputs only at the falling edge. Illegal strobe combinations are driven only in the phases the error checks target, and a reset follows them so that later checks start from clear flags.

// File: rtl/blkcmd_pkg.sv
package blkcmd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2,
    ST_POST = 2'd3
  } seq_st_e;

  localparam logic OP_READ  = 1'b0;
  localparam logic OP_WRITE = 1'b1;

  localparam int ALIGN_BITS = 3;
endpackage

// File: rtl/blkcmd_tracker.sv
module blkcmd_tracker #(
  parameter int MAX_OUTST  = 256,
  parameter int RD_CREDITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic acc,
  input  logic acc_is_rd,
  input  logic cmd_done,
  input  logic credit_ret,
  output logic limit_hit,
  output logic busy
);
  localparam int OUT_W = $clog2(MAX_OUTST + 1);
  localparam int CR_W  = $clog2(RD_CREDITS + 1);

  logic [OUT_W-1:0] outst_q;
  logic [CR_W-1:0]  cred_q;
  logic             done_eff, take, ret_eff;

  assign done_eff  = cmd_done && (outst_q != '0);
  assign take      = acc && acc_is_rd;
  assign ret_eff   = credit_ret && ((cred_q != CR_W'(RD_CREDITS)) || take);
  assign limit_hit = (outst_q == OUT_W'(MAX_OUTST)) || (cred_q == '0);
  assign busy      = (outst_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      outst_q <= '0;
      cred_q  <= CR_W'(RD_CREDITS);
    end else begin
      outst_q <= outst_q + OUT_W'(acc) - OUT_W'(done_eff);
      cred_q  <= cred_q - CR_W'(take) + CR_W'(ret_eff);
    end
  end

  // R8: acceptance never pushes past the queue limit
  p_queue_cap_r8: assert property (@(posedge clk) disable iff (rst)
    acc |-> (outst_q != OUT_W'(MAX_OUTST)));

  // R9: a read is only accepted with a credit in hand
  p_credit_avail_r9: assert property (@(posedge clk) disable iff (rst)
    take |-> (cred_q != '0));

  // R10: busy follows every acceptance
  p_busy_rise_r10: assert property (@(posedge clk) disable iff (rst)
    acc |=> busy);
endmodule

// File: rtl/blkcmd_wbuf.sv
module blkcmd_wbuf #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              wd_ready,
  output logic              wd_valid,
  output logic [DATA_W-1:0] wd_data,
  output logic              hold
);
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else if (load) vld_q <= 1'b1;
    else if (wd_ready) vld_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) dat_q <= din;
  end

  assign wd_valid = vld_q;
  assign wd_data  = dat_q;
  assign hold     = vld_q && !wd_ready;

  // R3: a beat waiting on the sink is not replaced
  p_beat_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !wd_ready) |=> (vld_q && $stable(dat_q)));
endmodule

// File: rtl/blkcmd_seq.sv
module blkcmd_seq import blkcmd_pkg::*; #(
  parameter int BEATS      = 512,
  parameter int PRE_STALL  = 9,
  parameter int POST_STALL = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_wr,
  input  logic       req_rd,
  input  logic       aligned,
  input  logic       slot_busy,
  input  logic       limit_hit,
  input  logic       wd_hold,
  output logic       stall,
  output logic       acc_cmd,
  output logic       acc_beat,
  output logic [1:0] err
);
  localparam int WIN_MAX = (PRE_STALL > POST_STALL) ? PRE_STALL : POST_STALL;
  localparam int WIN_W   = $clog2(WIN_MAX + 1);
  localparam int BEAT_W  = $clog2(BEATS);

  seq_st_e           st_q;
  logic [WIN_W-1:0]  win_q;
  logic [BEAT_W-1:0] beat_q;
  logic              is_wr_q;
  logic [1:0]        err_q;
  logic              in_idle, single, last_beat;

  always_comb begin
    in_idle = (st_q == ST_IDLE);
    unique case (st_q)
      ST_IDLE: stall = slot_busy || limit_hit;
      ST_DATA: stall = wd_hold;
      default: stall = 1'b1;
    endcase
    single    = req_wr ^ req_rd;
    acc_cmd   = in_idle && !stall && single && aligned;
    acc_beat  = req_wr && !req_rd && !stall &&
                ((in_idle && aligned) || (st_q == ST_DATA));
    last_beat = (st_q == ST_DATA) && acc_beat && (beat_q == BEAT_W'(BEATS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      win_q   <= '0;
      beat_q  <= '0;
      is_wr_q <= 1'b0;
      err_q   <= '0;
    end else begin
      if ((req_wr && req_rd) || (req_rd && st_q == ST_DATA)) err_q[0] <= 1'b1;
      if (in_idle && !stall && single && !aligned) err_q[1] <= 1'b1;
      unique case (st_q)
        ST_IDLE: if (acc_cmd) begin
          st_q    <= ST_PRE;
          win_q   <= WIN_W'(PRE_STALL - 1);
          is_wr_q <= req_wr;
          beat_q  <= BEAT_W'(1);
        end
        ST_PRE: begin
          if (win_q == '0) st_q <= is_wr_q ? ST_DATA : ST_IDLE;
          else win_q <= win_q - 1'b1;
        end
        ST_DATA: if (acc_beat) begin
          if (last_beat) begin
            st_q  <= ST_POST;
            win_q <= WIN_W'(POST_STALL - 1);
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        ST_POST: begin
          if (win_q == '0) st_q <= ST_IDLE;
          else win_q <= win_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign err = err_q;

  // R4: the cycle after an acceptance is always stalled
  p_pre_window_r4: assert property (@(posedge clk) disable iff (rst)
    $past(acc_cmd && !rst) |-> stall);

  // R7: a strobe clash is flagged
  p_clash_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (req_wr && req_rd) |=> err_q[0]);

  // R7: the clash flag is sticky
  p_clash_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    err_q[0] |=> err_q[0]);

  // R6: the alignment flag is sticky
  p_align_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    err_q[1] |=> err_q[1]);
endmodule

// File: rtl/blkcmd_front.sv
module blkcmd_front import blkcmd_pkg::*; #(
  parameter int ADDR_W     = 48,
  parameter int DATA_W     = 64,
  parameter int BEATS      = 512,
  parameter int PRE_STALL  = 9,
  parameter int POST_STALL = 1,
  parameter int MAX_OUTST  = 256,
  parameter int RD_CREDITS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              stall,
  output logic              busy,
  output logic [1:0]        proto_err,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_is_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              wd_valid,
  input  logic              wd_ready,
  output logic [DATA_W-1:0] wd_data,
  input  logic              cmd_done,
  input  logic              credit_ret
);
  logic              aligned, acc_cmd, acc_beat, limit_hit, wd_hold;
  logic              cv_q, cw_q;
  logic [ADDR_W-1:0] ca_q;

  assign aligned = (req_addr[ALIGN_BITS-1:0] == '0);

  blkcmd_seq #(.BEATS(BEATS), .PRE_STALL(PRE_STALL), .POST_STALL(POST_STALL)) u_seq (
    .clk(clk), .rst(rst), .req_wr(req_wr), .req_rd(req_rd), .aligned(aligned),
    .slot_busy(cv_q || wd_valid), .limit_hit(limit_hit), .wd_hold(wd_hold),
    .stall(stall), .acc_cmd(acc_cmd), .acc_beat(acc_beat), .err(proto_err));

  blkcmd_tracker #(.MAX_OUTST(MAX_OUTST), .RD_CREDITS(RD_CREDITS)) u_trk (
    .clk(clk), .rst(rst), .acc(acc_cmd), .acc_is_rd(req_rd), .cmd_done(cmd_done),
    .credit_ret(credit_ret), .limit_hit(limit_hit), .busy(busy));

  blkcmd_wbuf #(.DATA_W(DATA_W)) u_wbuf (
    .clk(clk), .rst(rst), .load(acc_beat), .din(wr_data), .wd_ready(wd_ready),
    .wd_valid(wd_valid), .wd_data(wd_data), .hold(wd_hold));

  always_ff @(posedge clk) begin
    if (rst) cv_q <= 1'b0;
    else if (acc_cmd) cv_q <= 1'b1;
    else if (cmd_ready) cv_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (acc_cmd) begin
      ca_q <= req_addr;
      cw_q <= req_wr ? OP_WRITE : OP_READ;
    end
  end

  assign cmd_valid    = cv_q;
  assign cmd_is_write = cw_q;
  assign cmd_addr     = ca_q;

  // R1: descriptor appears with the request's opcode and address
  p_desc_load_r1: assert property (@(posedge clk) disable iff (rst)
    acc_cmd |=> (cmd_valid && cmd_addr == $past(req_addr) && cmd_is_write == $past(req_wr)));

  // R6: only aligned addresses are accepted
  p_align_only_r6: assert property (@(posedge clk) disable iff (rst)
    acc_cmd |-> (req_addr[ALIGN_BITS-1:0] == '0));

  // R1: a waiting descriptor is held
  p_desc_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)));
endmodule

// File: tb/blkcmd_front_bench.sv
module blkcmd_front_bench;
  localparam int AW = 48;
  localparam int DW = 64;
  localparam int NB = 4;
  localparam int PRE = 9;
  localparam int POST = 1;
  localparam int MQ = 3;
  localparam int RC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_wr = 1'b0, req_rd = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic stall, busy, cmd_valid, cmd_is_write, wd_valid;
  logic [1:0] proto_err;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] wd_data;
  logic cmd_ready = 1'b1, wd_ready = 1'b1, cmd_done = 1'b0, credit_ret = 1'b0;

  int checks = 0, fails = 0;
  int nd = 0, nw = 0;
  logic          dlog_op[64];
  logic [AW-1:0] dlog_ad[64];
  logic [DW-1:0] wlog[64];

  always #2 clk = ~clk;

  blkcmd_front #(.ADDR_W(AW), .DATA_W(DW), .BEATS(NB), .PRE_STALL(PRE),
    .POST_STALL(POST), .MAX_OUTST(MQ), .RD_CREDITS(RC)) u_blkcmd_front (
    .clk(clk), .rst(rst), .req_wr(req_wr), .req_rd(req_rd), .req_addr(req_addr),
    .wr_data(wr_data), .stall(stall), .busy(busy), .proto_err(proto_err),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_is_write(cmd_is_write),
    .cmd_addr(cmd_addr), .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .cmd_done(cmd_done), .credit_ret(credit_ret));

  always @(posedge clk) begin
    if (!rst) begin
      if (cmd_valid && cmd_ready && nd < 64) begin
        dlog_op[nd] = cmd_is_write; dlog_ad[nd] = cmd_addr; nd = nd + 1;
      end
      if (wd_valid && wd_ready && nw < 64) begin
        wlog[nw] = wd_data; nw = nw + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_wr = 0; req_rd = 0; cmd_done = 0; credit_ret = 0; wd_ready = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); cmd_done = 1'b1;
    @(negedge clk); cmd_done = 1'b0;
  endtask

  task automatic pulse_credit();
    @(negedge clk); credit_ret = 1'b1;
    @(negedge clk); credit_ret = 1'b0;
  endtask

  // mode: 0 plain, 1 gaps and sink throttling, 2 read poke in data phase
  task automatic do_write(input logic [AW-1:0] a, input int tag, input int mode,
                          output int pre, output int post);
    int i = 0;
    int cyc = 0;
    bit poked = 0;
    bit drv, acc;
    pre = 0; post = 0;
    while (i < NB) begin
      @(negedge clk);
      wd_ready = (mode == 1) ? (cyc % 3 != 1) : 1'b1;
      cyc++;
      drv = !(mode == 1 && i > 0 && cyc % 4 == 0);
      req_rd = 1'b0;
      if (mode == 2 && i == 2 && !poked) begin
        drv = 0; req_rd = 1'b1; poked = 1;
      end
      req_wr = drv; req_addr = a; wr_data = {32'(tag), 32'(i)};
      #1;
      acc = drv && !stall;
      if (i == 1 && drv && stall) pre++;
      if (acc) i++;
    end
    @(negedge clk);
    req_wr = 0; req_rd = 0; wd_ready = 1;
    #1;
    while (stall && post < 20) begin
      post++; @(negedge clk); #1;
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, output int pre);
    int guard = 0;
    pre = 0;
    @(negedge clk);
    req_rd = 1'b1; req_addr = a;
    #1;
    while (stall && guard < 30) begin
      guard++; @(negedge clk); #1;
    end
    @(negedge clk);
    req_rd = 1'b0;
    #1;
    while (stall && pre < 30) begin
      pre++; @(negedge clk); #1;
    end
  endtask

  task automatic chk_beats(input int tag, input string req);
    for (int i = 0; i < NB; i++) begin
      logic [DW-1:0] e;
      e = {32'(tag), 32'(i)};
      chk(wlog[nw - NB + i] == e, req, "write beat", wlog[nw - NB + i], e);
    end
  endtask

  initial begin
    int pre, post, d0, w0;
    do_reset();
    @(negedge clk); #1;
    // R11 reset state
    chk(stall == 0, "R11", "stall", stall, 0);
    chk(busy == 0, "R11", "busy", busy, 0);
    chk(cmd_valid == 0, "R11", "cmd_valid", cmd_valid, 0);
    chk(wd_valid == 0, "R11", "wd_valid", wd_valid, 0);
    chk(proto_err == 0, "R11", "proto_err", proto_err, 0);

    // plain write
    do_write(48'h40, 1, 0, pre, post);
    chk(pre == PRE, "R4", "write pre stall", pre, PRE);
    chk(post == POST, "R5", "write post stall", post, POST);
    chk(pre + post >= 10, "R5", "total stall", pre + post, 10);
    chk(nd == 1, "R1", "descriptor count", nd, 1);
    chk(dlog_op[0] == 1'b1, "R1", "opcode write", dlog_op[0], 1);
    chk(dlog_ad[0] == 48'h40, "R1", "address", dlog_ad[0], 48'h40);
    chk(nw == NB, "R2", "beat count", nw, NB);
    chk_beats(1, "R2");
    chk(busy == 1, "R10", "busy while outstanding", busy, 1);
    pulse_done(); #1;
    chk(busy == 0, "R10", "busy after completion", busy, 0);

    // gaps and sink backpressure
    do_write(48'h80, 2, 1, pre, post);
    chk(nw == 2 * NB, "R3", "beat count with gaps", nw, 2 * NB);
    chk_beats(2, "R3");
    chk(nd == 2 && dlog_ad[1] == 48'h80, "R3", "descriptor", dlog_ad[1], 48'h80);
    pulse_done();

    // read
    w0 = nw;
    do_read(48'hc8, pre);
    chk(pre == PRE, "R4", "read pre stall", pre, PRE);
    chk(nd == 3 && dlog_op[2] == 1'b0, "R1", "opcode read", dlog_op[2], 0);
    chk(dlog_ad[2] == 48'hc8, "R1", "read address", dlog_ad[2], 48'hc8);
    chk(nw == w0, "R2", "no beats on read", nw, w0);
    chk(busy == 1, "R10", "busy during read", busy, 1);
    pulse_credit(); pulse_done(); #1;
    chk(busy == 0, "R10", "busy after read done", busy, 0);

    // misaligned
    d0 = nd;
    @(negedge clk); req_wr = 1; req_addr = 48'h13; wr_data = '1;
    repeat (3) @(negedge clk);
    req_wr = 0; #1;
    repeat (2) @(negedge clk); #1;
    chk(nd == d0, "R6", "misaligned not accepted", nd, d0);
    chk(proto_err == 2'b10, "R6", "align flag", proto_err, 2'b10);
    chk(busy == 0, "R6", "busy stays low", busy, 0);

    // strobe clash
    do_reset();
    @(negedge clk); #1;
    chk(proto_err == 0, "R11", "reset clears flags", proto_err, 0);
    d0 = nd;
    @(negedge clk); req_wr = 1; req_rd = 1; req_addr = 48'h100;
    repeat (2) @(negedge clk);
    req_wr = 0; req_rd = 0;
    repeat (3) @(negedge clk); #1;
    chk(nd == d0, "R7", "clash ignored", nd, d0);
    chk(proto_err == 2'b01, "R7", "clash flag", proto_err, 2'b01);
    chk(busy == 0, "R7", "no command counted", busy, 0);
    repeat (3) @(negedge clk); #1;
    chk(proto_err == 2'b01, "R7", "flag sticky", proto_err, 2'b01);

    // read poked into a write's data phase
    do_reset();
    d0 = nd;
    do_write(48'h200, 3, 2, pre, post);
    chk(proto_err == 2'b01, "R7", "read in data phase flagged", proto_err, 2'b01);
    chk(nd == d0 + 1 && dlog_op[d0] == 1'b1, "R7", "only the write taken", nd, d0 + 1);
    chk_beats(3, "R7");
    pulse_done();

    // queue limit
    do_reset();
    do_write(48'h08, 4, 0, pre, post);
    do_write(48'h10, 5, 0, pre, post);
    do_write(48'h18, 6, 0, pre, post);
    chk(post == 20, "R8", "stall held at queue limit", post, 20);
    d0 = nd;
    @(negedge clk); req_wr = 1; req_addr = 48'h20;
    repeat (5) @(negedge clk);
    req_wr = 0;
    @(negedge clk); #1;
    chk(nd == d0, "R8", "no accept when full", nd, d0);
    chk(stall == 1, "R8", "stall when full", stall, 1);
    pulse_done(); #1;
    chk(stall == 0, "R8", "stall released by completion", stall, 0);
    pulse_done(); pulse_done(); #1;
    chk(busy == 0, "R10", "busy low after last completion", busy, 0);

    // read credits
    do_read(48'h30, pre);
    pulse_done();
    do_read(48'h38, pre);
    chk(pre == 30, "R9", "stall held with no credit", pre, 30);
    pulse_done(); #1;
    chk(stall == 1, "R9", "stall with idle queue, no credit", stall, 1);
    pulse_credit(); #1;
    chk(stall == 0, "R9", "credit return releases stall", stall, 0);
    pulse_credit();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule